// File: doc/BRIEF.md
# Instruction Queue with Three-Way Dispatch

This block buffers up to eight fetched 32-bit instruction words between the fetch path and three execution units (branch, floating-point, integer). A pre-decoder tags every fetched word with a two-bit class. The queue keeps its occupied slots packed toward slot 0, the oldest entry. In any single cycle it can hand one instruction to each unit whose decode stage reports ready.

Issue is asymmetric. The integer unit reads only slot 0, which acts as its decode stage. The branch and floating-point units may each take the lowest-numbered matching entry among slots 0 to 3. Since entries can leave out of program order across units, the queue closes every gap in the same cycle and keeps the relative order of the survivors. The queue raises a fetch request whenever it has room and no fetch is in flight, and reports how many slots are free. A mispredict input discards every entry from a given slot upward. If a fetch is in flight at that moment, the response to it is thrown away.

Top module: `iq_dispatch`

## Requirements
- R1: While `rst` is high and on the first cycle after it, all dispatch valids are 0 and `fetch_req` is 0. The queue comes out of reset empty.
- R2: `fetch_req` is a one-cycle registered pulse. It is raised at an edge where no fetch is outstanding (or a response arrives at that edge), there is no flush, and at least one slot will be free. `fetch_slots` then holds the free-slot count after that edge. No second request is raised until a response arrives.
- R3: On `fill_valid`, the words whose `fill_mask` bits are set (contiguous from bit 0, word k in `fill_words[32k+:32]`, class in `fill_cls[2k+:2]`) are all written in one cycle. They go into the lowest free slots after the surviving entries, in word order.
- R4: Class 2'b00 (integer) is dispatched only from slot 0, and only when `int_ready` is high. An integer word in any higher slot waits.
- R5: Class 2'b01 (branch) and class 2'b10 (floating-point) are dispatched from slots 0..3 only, each when its own ready is high. If several matching entries are present, the lowest-numbered one goes first. At most one instruction per unit is dispatched per cycle.
- R6: Entries removed in a cycle may sit at any positions. The remaining entries are compacted toward slot 0 in the same cycle and keep their relative order.
- R7: A chosen instruction appears on its unit's port, with its valid high, exactly one cycle after the edge at which it was selected. Valid is low in every other cycle.
- R8: On `flush`, entries in slots at or above `flush_keep` are discarded. Nothing is dispatched and no fill is accepted at that edge.
- R9: If a fetch is outstanding when `flush` is seen, the next fill response is discarded without touching the queue. A new request follows at that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fill_valid | input | 1 | Fetch response present this cycle |
| fill_mask | input | 8 | Per-word valid flags, contiguous from bit 0 |
| fill_words | input | 256 | Eight 32-bit instruction words, word 0 oldest |
| fill_cls | input | 16 | Two-bit class per word from the pre-decoder |
| flush | input | 1 | Branch mispredict: discard younger entries |
| flush_keep | input | 4 | Number of oldest slots kept on flush |
| br_ready | input | 1 | Branch decode stage empty |
| fp_ready | input | 1 | Floating-point decode stage empty |
| int_ready | input | 1 | Integer decode stage empty |
| fetch_req | output | 1 | Request for a new fetch burst |
| fetch_slots | output | 4 | Free slots at the time of the request |
| br_valid | output | 1 | Branch dispatch valid |
| br_instr | output | 32 | Branch instruction word |
| fp_valid | output | 1 | Floating-point dispatch valid |
| fp_instr | output | 32 | Floating-point instruction word |
| int_valid | output | 1 | Integer dispatch valid |
| int_instr | output | 32 | Integer instruction word |

## Verification
The hardest state to reach is a mispredict that lands while a fetch is in flight. Reaching it needs a fill that leaves room, so a new request goes out at the same edge and the queue is left partly occupied with a request pending; the flush is then applied in that window. A stale burst is then delivered and must vanish, which the bench sees because the integer port stays idle and the fresh request reports all eight slots free. The window boundary is reached by filling so that floating-point and branch words sit in slots 4 and 5 behind integer words. Readies are then released one unit at a time, so each word crosses into slot 3 on a known edge.

// File: rtl/iq_pkg.sv
package iq_pkg;
  typedef enum logic [1:0] {
    CLS_INT  = 2'd0,
    CLS_BR   = 2'd1,
    CLS_FP   = 2'd2,
    CLS_NONE = 2'd3
  } iclass_e;
endpackage

// File: rtl/iq_select.sv
// Finds the lowest slot below WIN holding the wanted class.
module iq_select #(
  parameter int DEPTH = 8,
  parameter int WIN   = 4,
  localparam int IDXW = $clog2(DEPTH)
) (
  input  logic                 en,
  input  logic [DEPTH-1:0]     vld,
  input  logic [2*DEPTH-1:0]   cls,
  input  logic [1:0]           want,
  output logic                 hit,
  output logic [IDXW-1:0]      idx
);
  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int i = WIN - 1; i >= 0; i--) begin
      if (en && vld[i] && cls[2*i +: 2] == want) begin
        hit = 1'b1;
        idx = IDXW'(i);
      end
    end
  end
endmodule

// File: rtl/iq_store.sv
// Slot storage: removal, compaction, flush trim and burst append.
module iq_store #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 32,
  localparam int CNTW = $clog2(DEPTH + 1)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [DEPTH-1:0]         take,
  input  logic                     flush,
  input  logic [CNTW-1:0]          keep_cnt,
  input  logic                     fill_en,
  input  logic [DEPTH-1:0]         fill_mask,
  input  logic [DEPTH*WIDTH-1:0]   fill_data,
  input  logic [2*DEPTH-1:0]       fill_cls,
  output logic [DEPTH-1:0]         q_vld,
  output logic [DEPTH*WIDTH-1:0]   q_data,
  output logic [2*DEPTH-1:0]       q_cls,
  output logic [CNTW-1:0]          free_next
);
  logic [WIDTH-1:0] mem   [DEPTH];
  logic [1:0]       tag   [DEPTH];
  logic             vld   [DEPTH];
  logic [WIDTH-1:0] n_mem [DEPTH];
  logic [1:0]       n_tag [DEPTH];
  logic             n_vld [DEPTH];

  always_comb begin
    int n;
    n = 0;
    for (int j = 0; j < DEPTH; j++) begin
      n_mem[j] = mem[j];
      n_tag[j] = tag[j];
      n_vld[j] = 1'b0;
    end
    for (int i = 0; i < DEPTH; i++) begin
      if (vld[i] && !take[i] && (!flush || CNTW'(i) < keep_cnt)) begin
        n_mem[n] = mem[i];
        n_tag[n] = tag[i];
        n_vld[n] = 1'b1;
        n = n + 1;
      end
    end
    for (int k = 0; k < DEPTH; k++) begin
      if (fill_en && fill_mask[k] && (n < DEPTH)) begin
        n_mem[n] = fill_data[k*WIDTH +: WIDTH];
        n_tag[n] = fill_cls[2*k +: 2];
        n_vld[n] = 1'b1;
        n = n + 1;
      end
    end
    free_next = CNTW'(DEPTH - n);
  end

  always_ff @(posedge clk) begin
    for (int j = 0; j < DEPTH; j++) begin
      mem[j] <= n_mem[j];
      tag[j] <= n_tag[j];
      vld[j] <= rst ? 1'b0 : n_vld[j];
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_flat
    assign q_vld[g]               = vld[g];
    assign q_data[g*WIDTH +: WIDTH] = mem[g];
    assign q_cls[2*g +: 2]        = tag[g];
  end

  // Occupied slots always form a run from slot 0 upward.
  for (genvar g = 0; g + 1 < DEPTH; g++) begin : g_chk
    assert_packed_R6: assert property (@(posedge clk) disable iff (rst)
      q_vld[g+1] |-> q_vld[g]);
  end
endmodule

// File: rtl/iq_dispatch.sv
module iq_dispatch #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 32,
  parameter int WIN   = 4,
  localparam int IDXW = $clog2(DEPTH),
  localparam int CNTW = $clog2(DEPTH + 1)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   fill_valid,
  input  logic [DEPTH-1:0]       fill_mask,
  input  logic [DEPTH*WIDTH-1:0] fill_words,
  input  logic [2*DEPTH-1:0]     fill_cls,
  input  logic                   flush,
  input  logic [CNTW-1:0]        flush_keep,
  input  logic                   br_ready,
  input  logic                   fp_ready,
  input  logic                   int_ready,
  output logic                   fetch_req,
  output logic [CNTW-1:0]        fetch_slots,
  output logic                   br_valid,
  output logic [WIDTH-1:0]       br_instr,
  output logic                   fp_valid,
  output logic [WIDTH-1:0]       fp_instr,
  output logic                   int_valid,
  output logic [WIDTH-1:0]       int_instr
);
  import iq_pkg::*;

  logic [DEPTH-1:0]       q_vld;
  logic [DEPTH*WIDTH-1:0] q_data;
  logic [2*DEPTH-1:0]     q_cls;
  logic [CNTW-1:0]        free_next;
  logic [DEPTH-1:0]       take;
  logic                   br_hit, fp_hit, int_hit;
  logic [IDXW-1:0]        br_idx, fp_idx, int_idx;
  logic                   pending, squash, fill_en;

  iq_select #(.DEPTH(DEPTH), .WIN(WIN)) u_sel_br (
    .en(br_ready && !flush), .vld(q_vld), .cls(q_cls), .want(CLS_BR),
    .hit(br_hit), .idx(br_idx));
  iq_select #(.DEPTH(DEPTH), .WIN(WIN)) u_sel_fp (
    .en(fp_ready && !flush), .vld(q_vld), .cls(q_cls), .want(CLS_FP),
    .hit(fp_hit), .idx(fp_idx));
  iq_select #(.DEPTH(DEPTH), .WIN(1)) u_sel_int (
    .en(int_ready && !flush), .vld(q_vld), .cls(q_cls), .want(CLS_INT),
    .hit(int_hit), .idx(int_idx));

  always_comb begin
    take = '0;
    if (br_hit)  take[br_idx]  = 1'b1;
    if (fp_hit)  take[fp_idx]  = 1'b1;
    if (int_hit) take[int_idx] = 1'b1;
  end

  assign fill_en = fill_valid && !flush && !squash;

  iq_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_store (
    .clk(clk), .rst(rst), .take(take), .flush(flush), .keep_cnt(flush_keep),
    .fill_en(fill_en), .fill_mask(fill_mask), .fill_data(fill_words),
    .fill_cls(fill_cls), .q_vld(q_vld), .q_data(q_data), .q_cls(q_cls),
    .free_next(free_next));

  // Dispatch ports, registered.
  always_ff @(posedge clk) begin
    if (rst) begin
      br_valid  <= 1'b0;
      fp_valid  <= 1'b0;
      int_valid <= 1'b0;
      br_instr  <= '0;
      fp_instr  <= '0;
      int_instr <= '0;
    end else begin
      br_valid  <= br_hit;
      fp_valid  <= fp_hit;
      int_valid <= int_hit;
      if (br_hit)  br_instr  <= q_data[br_idx*WIDTH +: WIDTH];
      if (fp_hit)  fp_instr  <= q_data[fp_idx*WIDTH +: WIDTH];
      if (int_hit) int_instr <= q_data[int_idx*WIDTH +: WIDTH];
    end
  end

  // Fetch request: one outstanding burst at a time.
  always_ff @(posedge clk) begin
    if (rst) begin
      pending     <= 1'b0;
      squash      <= 1'b0;
      fetch_req   <= 1'b0;
      fetch_slots <= '0;
    end else begin
      fetch_req <= 1'b0;
      if (fill_valid) begin
        pending <= 1'b0;
        squash  <= 1'b0;
      end else if (flush && pending) begin
        squash <= 1'b1;
      end
      if (!flush && (!pending || fill_valid) && free_next != '0) begin
        fetch_req   <= 1'b1;
        pending     <= 1'b1;
        fetch_slots <= free_next;
      end
    end
  end

  assert_single_fetch_R2: assert property (@(posedge clk) disable iff (rst)
    fetch_req && !fill_valid |=> !fetch_req);

  assert_fill_fits_R3: assert property (@(posedge clk) disable iff (rst)
    fill_en |-> $countones(fill_mask) <= DEPTH - $countones(q_vld));

  assert_flush_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    flush |=> !br_valid && !fp_valid && !int_valid);
endmodule

// File: tb/iq_dispatch_bench.sv
module iq_dispatch_bench;
  localparam logic [1:0] CI = 2'd0, CB = 2'd1, CF = 2'd2;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         fill_valid = 1'b0;
  logic [7:0]   fill_mask = '0;
  logic [255:0] fill_words = '0;
  logic [15:0]  fill_cls = '0;
  logic         flush = 1'b0;
  logic [3:0]   flush_keep = '0;
  logic         br_ready = 1'b0, fp_ready = 1'b0, int_ready = 1'b0;
  logic         fetch_req;
  logic [3:0]   fetch_slots;
  logic         br_valid, fp_valid, int_valid;
  logic [31:0]  br_instr, fp_instr, int_instr;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  iq_dispatch u_iq_dispatch (
    .clk(clk), .rst(rst), .fill_valid(fill_valid), .fill_mask(fill_mask),
    .fill_words(fill_words), .fill_cls(fill_cls), .flush(flush),
    .flush_keep(flush_keep), .br_ready(br_ready), .fp_ready(fp_ready),
    .int_ready(int_ready), .fetch_req(fetch_req), .fetch_slots(fetch_slots),
    .br_valid(br_valid), .br_instr(br_instr), .fp_valid(fp_valid),
    .fp_instr(fp_instr), .int_valid(int_valid), .int_instr(int_instr));

  function automatic logic [31:0] w(input logic [15:0] t);
    return {t, 16'h0000};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // Advance one edge, then settle away from it.
  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic set_ready(input logic b, input logic f, input logic i);
    br_ready = b; fp_ready = f; int_ready = i;
  endtask

  task automatic do_fill(input int n, input logic [15:0] base, input logic [1:0] c [8]);
    fill_valid = 1'b1;
    fill_mask  = 8'((1 << n) - 1);
    fill_words = '0;
    fill_cls   = '0;
    for (int k = 0; k < n; k++) begin
      fill_words[32*k +: 32] = w(base + 16'(k));
      fill_cls[2*k +: 2]     = c[k];
    end
    tick();
    fill_valid = 1'b0;
    fill_mask  = '0;
  endtask

  task automatic t_reset();
    tick(); tick();
    chk("R1 br_valid", 32'(br_valid), 0);
    chk("R1 fp_valid", 32'(fp_valid), 0);
    chk("R1 int_valid", 32'(int_valid), 0);
    chk("R1 fetch_req", 32'(fetch_req), 0);
    rst = 1'b0;
    tick();
    chk("R2 first request", 32'(fetch_req), 1);
    chk("R2 first slots", 32'(fetch_slots), 8);
  endtask

  task automatic t_mixed();
    do_fill(8, 16'h0010, '{CB, CI, CF, CB, CF, CI, CI, CB});
    set_ready(0, 0, 1);
    tick();
    chk("R4 int blocked by branch in slot 0", 32'(int_valid), 0);
    set_ready(1, 1, 1);
    tick();
    chk("R5 br lowest", br_instr, w(16'h0010));
    chk("R5 fp lowest", fp_instr, w(16'h0012));
    chk("R4 int idle", 32'(int_valid), 0);
    chk("R2 request after room", 32'(fetch_req), 1);
    chk("R2 slots", 32'(fetch_slots), 2);
    tick();
    chk("R6 br after compaction", br_instr, w(16'h0013));
    chk("R6 fp after compaction", fp_instr, w(16'h0014));
    chk("R6 int slot 0", int_instr, w(16'h0011));
    chk("R2 no second request", 32'(fetch_req), 0);
    tick();
    chk("R6 int order", int_instr, w(16'h0015));
    chk("R5 br slot 2", br_instr, w(16'h0017));
    chk("R7 fp valid low", 32'(fp_valid), 0);
    tick();
    chk("R6 int last", int_instr, w(16'h0016));
    chk("R7 br valid low", 32'(br_valid), 0);
    tick();
    chk("R7 int valid low when empty", 32'(int_valid), 0);
    set_ready(0, 0, 0);
  endtask

  task automatic t_window();
    do_fill(8, 16'h0020, '{CI, CI, CI, CI, CF, CB, CI, CI});
    set_ready(1, 1, 0);
    tick();
    chk("R5 fp in slot 4 waits", 32'(fp_valid), 0);
    chk("R5 br in slot 5 waits", 32'(br_valid), 0);
    set_ready(1, 1, 1);
    tick();
    chk("R4 int", int_instr, w(16'h0020));
    chk("R5 fp still outside", 32'(fp_valid), 0);
    tick();
    chk("R5 fp from slot 3", fp_instr, w(16'h0024));
    chk("R4 int", int_instr, w(16'h0021));
    chk("R5 br in slot 4 waits", 32'(br_valid), 0);
    tick();
    chk("R5 br from slot 2", br_instr, w(16'h0025));
    chk("R4 int", int_instr, w(16'h0022));
    tick();
    chk("R4 int", int_instr, w(16'h0023));
    tick();
    chk("R6 int", int_instr, w(16'h0026));
    tick();
    chk("R6 int", int_instr, w(16'h0027));
    set_ready(0, 0, 0);
    tick();
  endtask

  task automatic t_flush();
    do_fill(6, 16'h0030, '{CI, CI, CI, CI, CI, CI, CI, CI});
    chk("R2 re-request on response", 32'(fetch_req), 1);
    chk("R2 slots", 32'(fetch_slots), 2);
    flush = 1'b1; flush_keep = 4'd2; int_ready = 1'b1;
    tick();
    flush = 1'b0;
    chk("R8 no dispatch on flush", 32'(int_valid), 0);
    tick();
    chk("R8 kept entry 0", int_instr, w(16'h0030));
    tick();
    chk("R8 kept entry 1", int_instr, w(16'h0031));
    tick();
    chk("R8 younger discarded", 32'(int_valid), 0);
    do_fill(3, 16'h0040, '{CI, CI, CI, CI, CI, CI, CI, CI});
    chk("R9 request after stale burst", 32'(fetch_req), 1);
    chk("R9 queue still empty", 32'(fetch_slots), 8);
    tick();
    chk("R9 stale words not dispatched", 32'(int_valid), 0);
    do_fill(1, 16'h0050, '{CI, CI, CI, CI, CI, CI, CI, CI});
    chk("R3 slots after one-word fill", 32'(fetch_slots), 7);
    tick();
    chk("R3 fresh word dispatched", int_instr, w(16'h0050));
    chk("R7 int valid", 32'(int_valid), 1);
    int_ready = 1'b0;
  endtask

  initial begin
    #2;
    t_reset();
    t_mixed();
    t_window();
    t_flush();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule